// File: doc/BRIEF.md
# Two-Wire Bus Start/Stop Condition Detector

This block watches the clock line (SCL) and data line (SDA) of a two-wire serial bus and reports framing conditions. It runs from a system clock that is much faster than the bus. Each line is first brought into the system domain through a synchroniser. It then passes through a short majority filter, so that slow or noisy bus edges give one clean transition. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Each one is reported as a single-cycle pulse.

The block also drives a level, `bus_active`, that is high from a START until the next STOP. Any STOP drops this level at once, even a STOP in the middle of a byte. Clock pulses on an idle bus never raise it. A START seen while the bus is already active is a repeated start: it pulses `start_pulse` again, and downstream frame logic uses that pulse to restart. The block does no data decoding, arbitration or clock stretching.

Top module: `bus_cond_detect`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `start_pulse`, `stop_pulse` and `bus_active` are all 0. The lines are taken as high (idle) out of reset.
- R2: When SDA goes from 1 to 0 while SCL stays 1, `start_pulse` is high for exactly one cycle. That cycle begins five clock edges after the first edge that samples the new SDA level.
- R3: When SDA goes from 0 to 1 while SCL stays 1, `stop_pulse` is high for exactly one cycle, with the same latency as R2.
- R4: `bus_active` rises in the same cycle as `start_pulse` and falls in the same cycle as `stop_pulse`, even when the STOP arrives mid-byte. It holds its value in all other cycles, and the two pulses are never high together.
- R5: SDA transitions made while SCL is low produce no pulse and leave `bus_active` unchanged.
- R6: SCL toggling on an idle bus (SDA high) produces no pulse, and `bus_active` stays 0.
- R7: A STOP followed by a START inside one SCL high period gives a `stop_pulse` and then, in a later cycle, a `start_pulse`. `bus_active` ends at 1.
- R8: A START while `bus_active` is 1 pulses `start_pulse`, and `bus_active` stays 1.
- R9: A level on either line that lasts only one system clock sample is rejected and has no effect at the outputs. A level held for at least two consecutive samples is accepted.
- R10: If SCL and SDA change in the same filtered sample, no condition is reported, because SCL must be high both before and after the SDA edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous to clk |
| sda_in | input | 1 | Bus data line, asynchronous to clk |
| start_pulse | output | 1 | One-cycle pulse on a START condition |
| stop_pulse | output | 1 | One-cycle pulse on a STOP condition |
| bus_active | output | 1 | High between a START and the next STOP |

## Verification
The bench drives several bus patterns, and each one targets a specific way a flawed design would fail:
- A STOP and a START inside one SCL high period: a detector that needs SCL to go low between them would miss the second START and leave the bus idle.
- A STOP in the middle of a byte: a design that honours only well-formed STOPs would stay active and hang the frame.
- SCL toggling on an idle bus, and SDA data edges while SCL is low: an edge detector that does not qualify edges by SCL level would report false conditions on these.
- A one-sample SDA glitch, and SCL and SDA changing together: an unfiltered detector would pulse on the glitch, and one that checks SCL on only one side of the edge would pulse on the simultaneous change.

// File: rtl/bus_cond_pkg.sv
package bus_cond_pkg;

  // Line order inside the filter bank
  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int NUM_LINES = 2;

  typedef struct packed {
    logic scl;
    logic sda;
  } bus_lines_t;

endpackage

// File: rtl/bus_line_filter.sv
module bus_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_filt
);

  localparam int CNT_W = $clog2(FILT_TAPS + 1);
  localparam int MAJ   = FILT_TAPS / 2;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;
  logic [CNT_W-1:0]       ones;
  logic                   filt_q;

  // Synchroniser chain, reset to the idle-high bus level
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end
  end

  // Sample history feeding the vote
  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '1;
    end else begin
      hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
    end
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < FILT_TAPS; i++) begin
      ones = ones + CNT_W'(hist_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
    end else begin
      filt_q <= (ones > CNT_W'(MAJ));
    end
  end

  assign line_filt = filt_q;

endmodule

// File: rtl/bus_cond_decode.sv
module bus_cond_decode
  import bus_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_lines_t lines,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       bus_active
);

  bus_lines_t prev_q;
  logic       scl_held_high;
  logic       sda_fall;
  logic       sda_rise;
  logic       start_q;
  logic       stop_q;
  logic       active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '{scl: 1'b1, sda: 1'b1};
    end else begin
      prev_q <= lines;
    end
  end

  // SCL must be high on both sides of the SDA edge
  assign scl_held_high = lines.scl & prev_q.scl;
  assign sda_fall      = prev_q.sda & ~lines.sda;
  assign sda_rise      = ~prev_q.sda & lines.sda;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= 1'b0;
      stop_q   <= 1'b0;
      active_q <= 1'b0;
    end else begin
      start_q <= scl_held_high & sda_fall;
      stop_q  <= scl_held_high & sda_rise;
      if (scl_held_high & sda_fall) begin
        active_q <= 1'b1;
      end else if (scl_held_high & sda_rise) begin
        active_q <= 1'b0;
      end
    end
  end

  assign start_pulse = start_q;
  assign stop_pulse  = stop_q;
  assign bus_active  = active_q;

endmodule

// File: rtl/bus_cond_detect.sv
module bus_cond_detect
  import bus_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic start_pulse,
  output logic stop_pulse,
  output logic bus_active
);

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] filt_lines;
  bus_lines_t           clean;

  assign raw_lines[LINE_SCL] = scl_in;
  assign raw_lines[LINE_SDA] = sda_in;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    bus_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk      (clk),
      .rst      (rst),
      .line_in  (raw_lines[g]),
      .line_filt(filt_lines[g])
    );
  end

  assign clean.scl = filt_lines[LINE_SCL];
  assign clean.sda = filt_lines[LINE_SDA];

  bus_cond_decode u_decode (
    .clk        (clk),
    .rst        (rst),
    .lines      (clean),
    .start_pulse(start_pulse),
    .stop_pulse (stop_pulse),
    .bus_active (bus_active)
  );

endmodule

// File: rtl/bus_cond_detect_chk.sv
module bus_cond_detect_chk #(
  parameter int QUIET_LIMIT = 8
) (
  input logic clk,
  input logic rst,
  input logic scl_in,
  input logic sda_in,
  input logic start_pulse,
  input logic stop_pulse,
  input logic bus_active
);

  logic [7:0] sda_quiet_q;
  logic       sda_last_q;

  // Counts cycles since SDA last changed at the input
  always_ff @(posedge clk) begin
    if (rst) begin
      sda_quiet_q <= '0;
      sda_last_q  <= sda_in;
    end else begin
      sda_last_q <= sda_in;
      if (sda_in != sda_last_q) begin
        sda_quiet_q <= '0;
      end else if (sda_quiet_q != 8'hFF) begin
        sda_quiet_q <= sda_quiet_q + 8'd1;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!start_pulse && !stop_pulse && !bus_active)); // R1

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse); // R2

  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |=> !stop_pulse); // R3

  AST_NO_DOUBLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(start_pulse && stop_pulse)); // R4

  AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> bus_active); // R4

  AST_STOP_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> !bus_active); // R4

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!start_pulse && !stop_pulse) |-> $stable(bus_active)); // R4

  AST_NO_SDA_EDGE_NO_COND: assert property (@(posedge clk) disable iff (rst)
    (sda_quiet_q >= 8'(QUIET_LIMIT)) |-> (!start_pulse && !stop_pulse)); // R6

endmodule

bind bus_cond_detect bus_cond_detect_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_in     (scl_in),
  .sda_in     (sda_in),
  .start_pulse(start_pulse),
  .stop_pulse (stop_pulse),
  .bus_active (bus_active)
);

// File: tb/bus_cond_detect_tb.sv
module bus_cond_detect_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda = 1'b1;
  logic start_pulse, stop_pulse, bus_active;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int obs_start = 0, obs_stop = 0;
  int last_start_cyc = 0, last_stop_cyc = 0;

  always #10 clk = ~clk; // 50 MHz

  bus_cond_detect u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_active(bus_active)
  );

  // Behavioural reference: sample history, 2-of-3 vote, edge rules
  logic hs[$];
  logic hc[$];
  logic m_start = 1'b0, m_stop = 1'b0, m_active = 1'b0;

  function automatic logic vote(logic a, logic b, logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      hs = {};
      hc = {};
      for (int i = 0; i < 8; i++) begin
        hs.push_front(1'b1);
        hc.push_front(1'b1);
      end
      m_start = 1'b0; m_stop = 1'b0; m_active = 1'b0;
    end else begin
      logic fs_new, fs_old, fc_new, fc_old;
      hs.push_front(sda);
      hc.push_front(scl);
      void'(hs.pop_back());
      void'(hc.pop_back());
      fs_new = vote(hs[4], hs[5], hs[6]);
      fs_old = vote(hs[5], hs[6], hs[7]);
      fc_new = vote(hc[4], hc[5], hc[6]);
      fc_old = vote(hc[5], hc[6], hc[7]);
      m_start = fc_new & fc_old & fs_old & ~fs_new;
      m_stop  = fc_new & fc_old & ~fs_old & fs_new;
      if (m_start) m_active = 1'b1;
      else if (m_stop) m_active = 1'b0;
    end
  end

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    tests++;
    if (start_pulse !== m_start) begin
      fails++;
      $display("FAIL R2 start_pulse cyc %0d: got %b exp %b", cyc, start_pulse, m_start);
    end
    tests++;
    if (stop_pulse !== m_stop) begin
      fails++;
      $display("FAIL R3 stop_pulse cyc %0d: got %b exp %b", cyc, stop_pulse, m_stop);
    end
    tests++;
    if (bus_active !== m_active) begin
      fails++;
      $display("FAIL R4 bus_active cyc %0d: got %b exp %b", cyc, bus_active, m_active);
    end
    if (start_pulse === 1'b1) begin obs_start++; last_start_cyc = cyc; end
    if (stop_pulse === 1'b1)  begin obs_stop++;  last_stop_cyc  = cyc; end
  end

  task automatic drive(input logic c, input logic d, input int n);
    @(negedge clk);
    scl = c;
    sda = d;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (10) @(negedge clk);
  endtask

  int s0, p0;

  initial begin
    repeat (4) @(negedge clk);
    check("R1 start after reset", int'(start_pulse), 0);
    check("R1 active after reset", int'(bus_active), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first cycle active", int'(bus_active), 0);

    // R6: SCL toggling on idle bus
    s0 = obs_start; p0 = obs_stop;
    for (int i = 0; i < 5; i++) begin
      drive(0, 1, 6);
      drive(1, 1, 6);
    end
    settle();
    check("R6 idle toggles starts", obs_start - s0, 0);
    check("R6 idle active", int'(bus_active), 0);

    // R2: START
    s0 = obs_start;
    drive(1, 0, 6);
    settle();
    check("R2 start count", obs_start - s0, 1);
    check("R2 active set", int'(bus_active), 1);

    // R5: data bits, SDA changes only while SCL low
    s0 = obs_start; p0 = obs_stop;
    drive(0, 0, 6);
    for (int b = 0; b < 8; b++) begin
      drive(0, logic'(b[0]), 6);
      drive(1, logic'(b[0]), 6);
      drive(0, logic'(b[0]), 6);
    end
    settle();
    check("R5 data edges starts", obs_start - s0, 0);
    check("R5 data edges stops", obs_stop - p0, 0);
    check("R5 active kept", int'(bus_active), 1);

    // R8: repeated START
    s0 = obs_start;
    drive(0, 1, 6);
    drive(1, 1, 6);
    drive(1, 0, 6);
    settle();
    check("R8 repeated start count", obs_start - s0, 1);
    check("R8 active stays", int'(bus_active), 1);

    // R4: STOP mid-byte
    p0 = obs_stop;
    drive(0, 0, 6);
    drive(0, 1, 6);
    drive(1, 1, 6);
    drive(0, 1, 6);
    drive(0, 0, 6);
    drive(1, 0, 6);
    drive(1, 1, 6);
    settle();
    check("R4 mid-byte stop count", obs_stop - p0, 1);
    check("R4 idle after stop", int'(bus_active), 0);

    // R7: START, then STOP and START in one SCL high period
    drive(1, 0, 6);
    drive(0, 0, 6);
    s0 = obs_start; p0 = obs_stop;
    drive(1, 0, 6);
    drive(1, 1, 6);
    drive(1, 0, 6);
    settle();
    check("R7 stop count", obs_stop - p0, 1);
    check("R7 start count", obs_start - s0, 1);
    check("R7 order", int'(last_start_cyc > last_stop_cyc), 1);
    check("R7 active", int'(bus_active), 1);

    // Return to idle with a clean STOP
    drive(0, 0, 6);
    drive(1, 0, 6);
    drive(1, 1, 6);
    settle();

    // R9: single-sample glitches on both lines
    s0 = obs_start; p0 = obs_stop;
    drive(1, 0, 1);
    drive(1, 1, 6);
    drive(0, 1, 1);
    drive(1, 1, 6);
    settle();
    check("R9 glitch starts", obs_start - s0, 0);
    check("R9 glitch active", int'(bus_active), 0);
    // two-sample low is accepted
    drive(1, 0, 2);
    drive(1, 1, 6);
    settle();
    check("R9 two-sample start", obs_start - s0, 1);
    check("R9 two-sample stop", obs_stop - p0, 1);

    // R10: SCL rising and SDA falling together
    s0 = obs_start;
    drive(0, 1, 6);
    drive(1, 0, 6);
    settle();
    check("R10 simultaneous change", obs_start - s0, 0);
    check("R10 active", int'(bus_active), 0);
    drive(0, 0, 6);
    drive(0, 1, 6);
    drive(1, 1, 6);
    settle();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule